// File: doc/BRIEF.md
# Serial line encoder: word serializer with self-synchronizing scrambler and NRZI stage

The block turns a stream of 10-bit words into a single serial bit stream for a high-rate video link. One bit leaves per bit-rate clock enable, least significant bit first. Before it reaches the output, each bit is scrambled by a self-synchronizing scrambler with a nine-stage history and taps at four and nine bits. The scrambled bit then passes through an NRZ-to-NRZI stage, in which a one becomes a change of line level and a zero keeps the level. The scrambling spreads the spectrum and removes long runs. The NRZI step makes the receiver insensitive to line polarity.

A word is offered on `word_in` with `word_ld` high. The framer accepts it only on an enabled cycle at a word boundary: while idle, or on the enable that follows the tenth bit of the word in flight. Words therefore follow one another with no gap. When no word is offered at a boundary, the framer returns to idle and feeds zeros into the coding chain, so the line keeps its coded activity. The `bypass` input sends the raw serialized bits straight to the output. While it is high, the scrambler history and the NRZI level are frozen.

The framer has two states. In S_IDLE no word is in flight. In S_SHIFT a word is being sent. The transitions are as follows. T_START goes from S_IDLE to S_SHIFT when a word is accepted. T_NEXT stays in S_SHIFT while bits remain. T_RELOAD stays in S_SHIFT when the next word is accepted at a boundary. T_DRAIN goes from S_SHIFT to S_IDLE when no word is offered at a boundary. T_WAIT keeps S_IDLE while nothing is offered.

Top module: `hd_serial_tx`

## Requirements
- R1: While reset is low and after it is released, `sdo` is 0, and the scrambler history, the NRZI level and the shifter are all zero. The first coded bits are therefore computed from an all-zero history.
- R2: `sdo` changes only on a clock edge where `bit_en` is high. It is registered, and it shows the coded bit of that enable right after the edge.
- R3: A word accepted on an enable emits `word_in[0]` on that enable and bits 1 to 9 on the next nine enables, in that order. The next word can be accepted on the following enable, so there is no idle bit between words.
- R4: `word_ld` has no effect while bits of the current word remain to be sent, or on a cycle where `bit_en` is low. `word_in` is ignored on those cycles.
- R5: When a boundary enable arrives with `word_ld` low, the bit fed into the chain is 0. The framer then waits in idle until a word is offered on an enable.
- R6: With `bypass` low, the scrambled bit is s(n) = d(n) XOR s(n-4) XOR s(n-9). Here d is the raw serialized bit and s is the scrambler's own earlier output.
- R7: With `bypass` low, the NRZI level is y(n) = s(n) XOR y(n-1) and `sdo` shows y(n). A 1 is a transition and a 0 holds the level.
- R8: With `bypass` high, `sdo` shows the raw serialized bit. The scrambler history and the NRZI level are held and resume from their held values when `bypass` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate clock enable; one serial bit per high cycle |
| word_ld | input | 1 | Offers `word_in` for loading at a word boundary |
| word_in | input | WORD_W | Parallel word, sent least significant bit first |
| bypass | input | 1 | High: raw bits to output, coding state frozen |
| sdo | output | 1 | Serial data out |

## Verification
Single-bit words (001, 200), all-ones and alternating words are sent with bypass high, so that bit order and word boundaries show on the raw line. They are then sent with bypass low, where the same patterns show the four-bit and nine-bit feedback taps and the NRZI transitions separately. A load held high with changing data in mid-word tells correct boundary acceptance apart from early loads. Sparse enables tell the gating apart from free running, and a gap with no words exposes the zero fill. Toggling bypass in mid-stream shows whether the coding state is frozen or keeps advancing.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;

    localparam int WORD_W = 10;
    localparam int TAP_A  = 4;
    localparam int TAP_B  = 9;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_SHIFT = 1'b1
    } fr_state_e;

endpackage

// File: rtl/hdtx_framer.sv
module hdtx_framer
    import hdtx_pkg::*;
#(
    parameter int WORD_W = hdtx_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              word_ld,
    input  logic [WORD_W-1:0] word_in,
    output logic              raw_bit
);

    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST = CW'(WORD_W);

    fr_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic              boundary;
    logic              take;

    assign boundary = (state_q == S_IDLE) || (cnt_q == LAST);
    assign take     = bit_en && word_ld && boundary;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take) state_d = S_SHIFT;          // T_START / T_WAIT
            S_SHIFT: if (boundary && !take) state_d = S_IDLE; // T_DRAIN, else T_NEXT / T_RELOAD
            default: state_d = S_IDLE;
        endcase
    end

    // output and datapath process
    always_comb begin
        cnt_d   = '0;
        sh_d    = sh_q;
        raw_bit = 1'b0;
        if (take) begin
            raw_bit = word_in[0];
            sh_d    = word_in >> 1;
            cnt_d   = CW'(1);
        end else begin
            unique case (state_q)
                S_SHIFT: begin
                    if (!boundary) begin
                        raw_bit = sh_q[0];
                        sh_d    = sh_q >> 1;
                        cnt_d   = cnt_q + CW'(1);
                    end
                end
                S_IDLE:  raw_bit = 1'b0;
                default: raw_bit = 1'b0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else if (bit_en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // R3: bit count never passes the word width
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: mid-word enables advance the count by exactly one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state_q == S_SHIFT && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + CW'(1));

    // R4: no reload while bits remain
    a_r4_no_mid_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && word_ld && state_q == S_SHIFT && cnt_q != LAST && cnt_q != CW'(0))
        |=> cnt_q != CW'(1));

    // R5: idle with nothing offered stays idle
    a_r5_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state_q == S_IDLE && !word_ld) |=> state_q == S_IDLE);

endmodule

// File: rtl/hdtx_scrambler.sv
module hdtx_scrambler #(
    parameter int TAP_A = hdtx_pkg::TAP_A,
    parameter int TAP_B = hdtx_pkg::TAP_B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic dout
);

    logic [TAP_B-1:0] hist_q;

    // hist_q[k] holds the output from k+1 bits ago
    assign dout = din ^ hist_q[TAP_A-1] ^ hist_q[TAP_B-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (adv) begin
            hist_q <= {hist_q[TAP_B-2:0], dout};
        end
    end

    // R8: history frozen when not advancing
    a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist_q));

    // R6: history ages by one position per advance
    a_r6_hist_age: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> hist_q[TAP_B-1:1] == $past(hist_q[TAP_B-2:0]));

endmodule

// File: rtl/hdtx_nrzi.sv
module hdtx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic dout
);

    logic lvl_q;

    assign dout = din ^ lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (adv) begin
            lvl_q <= dout;
        end
    end

    // R7: a one toggles the level
    a_r7_one_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && din) |=> lvl_q != $past(lvl_q));

    // R7: a zero keeps the level
    a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !din) |=> $stable(lvl_q));

endmodule

// File: rtl/hd_serial_tx.sv
module hd_serial_tx #(
    parameter int WORD_W = hdtx_pkg::WORD_W,
    parameter int TAP_A  = hdtx_pkg::TAP_A,
    parameter int TAP_B  = hdtx_pkg::TAP_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              word_ld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              bypass,
    output logic              sdo
);

    logic raw_bit;
    logic scr_bit;
    logic line_bit;
    logic code_adv;
    logic sdo_q;

    assign code_adv = bit_en && !bypass;

    hdtx_framer #(.WORD_W(WORD_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .word_ld (word_ld),
        .word_in (word_in),
        .raw_bit (raw_bit)
    );

    hdtx_scrambler #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (code_adv),
        .din   (raw_bit),
        .dout  (scr_bit)
    );

    hdtx_nrzi u_nrzi (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (code_adv),
        .din   (scr_bit),
        .dout  (line_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (bit_en) begin
            sdo_q <= bypass ? raw_bit : line_bit;
        end
    end

    assign sdo = sdo_q;

    // R1: output low on the first cycle out of reset
    a_r1_reset_low: assert property (@(posedge clk)
        $rose(rst_n) |-> sdo_q == 1'b0);

    // R2: no enable, no change
    a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(sdo_q));

    // R8: bypass shows the raw bit
    a_r8_raw_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bypass) |=> sdo_q == $past(raw_bit));

endmodule

// File: tb/hd_serial_tx_test.sv
`timescale 1ns/1ps
module hd_serial_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       word_ld = 1'b0;
    logic [9:0] word_in = '0;
    logic       bypass = 1'b0;
    logic       sdo;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    // reference model state
    bit  bitq[$];
    bit  scrq[$];
    bit  nrz = 0;
    bit  exp_sdo = 0;
    bit  last_acc = 0;
    int  widx = 0;

    always #2.5 clk = ~clk;

    hd_serial_tx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .word_ld (word_ld),
        .word_in (word_in),
        .bypass  (bypass),
        .sdo     (sdo)
    );

    function automatic logic [9:0] pat(input int k);
        case (k % 6)
            0: return 10'h001;
            1: return 10'h3FF;
            2: return 10'h200;
            3: return 10'h2AA;
            4: return 10'h000;
            default: return 10'((k * 37 + 5) & 1023);
        endcase
    endfunction

    task automatic check(input string tag);
        total++;
        if (sdo !== exp_sdo) begin
            bad++;
            $display("FAIL %s: sdo=%b expected=%b", tag, sdo, exp_sdo);
        end
    endtask

    // one cycle: check previous result, drive new inputs, advance model
    task automatic step(input bit en, input bit ld, input logic [9:0] w,
                        input bit byp, input string tag);
        @(negedge clk);
        check(tag);
        bit_en  = en;
        word_ld = ld;
        word_in = w;
        bypass  = byp;
        last_acc = 0;
        if (en) begin
            bit raw;
            bit s;
            if (bitq.size() == 0 && ld) begin
                for (int i = 0; i < 10; i++) bitq.push_back(w[i]);
                last_acc = 1;
            end
            raw = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
            if (byp) begin
                exp_sdo = raw;
            end else begin
                s = raw ^ scrq[5] ^ scrq[0];
                scrq.push_back(s);
                void'(scrq.pop_front());
                nrz = nrz ^ s;
                exp_sdo = nrz;
            end
        end
    endtask

    task automatic run(input int cycles, input int en_every, input bit byp,
                       input int words, input bit garbage, input string tag);
        int sent = 0;
        for (int c = 0; c < cycles; c++) begin
            bit en;
            bit ld;
            logic [9:0] w;
            en = (c % en_every) == 0;
            ld = sent < words;
            if (bitq.size() == 0 || !garbage) w = pat(widx);
            else w = 10'((c * 91 + 17) & 1023);
            if (garbage && bitq.size() > 0) ld = 1;
            step(en, ld, w, byp, tag);
            if (last_acc) begin
                widx++;
                sent++;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 9; i++) scrq.push_back(1'b0);
        // R1: output held low during reset
        repeat (4) begin
            @(negedge clk);
            check("R1 in reset");
        end
        rst_n = 1'b1;
        run(30, 1, 0, 100, 0, "R1 first bits from zero state");
        run(60, 1, 1, 100, 0, "R3 lsb first back-to-back");
        run(60, 1, 1, 100, 1, "R4 mid-word load ignored");
        run(60, 2, 1, 100, 1, "R4 load without enable ignored");
        run(45, 1, 1, 2, 0, "R5 zero fill when idle");
        run(80, 1, 0, 100, 0, "R6 scrambler taps");
        run(50, 1, 0, 0, 0, "R7 nrzi on idle fill");
        run(90, 3, 0, 100, 0, "R2 sparse enables");
        run(35, 1, 1, 100, 0, "R8 bypass raw");
        run(60, 1, 0, 100, 0, "R8 coding resumes");
        run(25, 1, 1, 100, 0, "R8 bypass again");
        run(40, 1, 0, 100, 0, "R8 coding resumes again");
        @(negedge clk);
        check("R2 final");
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule